// File: doc/BRIEF.md
# Interrupt Flag and Enable Controller

This block keeps the interrupt state of a timekeeping peripheral. Three event sources drive it with single-cycle pulses: the periodic tick, the alarm match and the end of a time update. Each pulse sets a sticky flag. A control register holds one enable bit per source. An interrupt request of open-drain type is pulled low while any flag is set and its enable bit is also set.

Software reads the status register to find out which events happened. That read returns the flags and a summary bit, and the same read clears every flag, so the request is released. An event that arrives in the same cycle as the clearing read is not lost. It stays set for the next read. Reset clears the enables and the flags and releases the request line. Until software writes the enables again, no source can raise an interrupt.

The register port is a plain single-cycle strobe interface with registered read data. The open-drain pin is given as a drive-low enable, and the pad outside the block ties its data to 0.

Top module: `irq_flag_ctrl`

## Requirements
- R1: A one-cycle pulse on `evt_pulse[i]` sets flag i at the clock edge where the pulse is sampled. The flag is set whatever its enable bit holds. In the status register the update-ended flag (i=0) is bit 4, the alarm flag (i=1) is bit 5 and the periodic flag (i=2) is bit 6.
- R2: A flag stays set until the status register is read or reset is applied.
- R3: `irq_oe` is 1 (pin driven low) exactly when at least one flag is set and its enable bit is also set. It follows a change of flags or enables from the clock edge that makes the change.
- R4: A read with `reg_addr` = 2 (status) delivers the flags on `reg_rdata` after the clock edge that samples the read. The same edge clears all flags and releases `irq_oe`.
- R5: Bit 7 of the status read data is 1 when some flag was set with its enable bit set at the time of the read. It is 0 when the only flags set have their enables cleared.
- R6: An event pulse in the same cycle as a status read does not appear in that read's data. Its flag is still set after the read and shows in the next status read.
- R7: A write with `reg_addr` = 1 (control) loads the enables from `reg_wdata` bits 6:4, in the same order as the flags. A read of address 1 returns the enables in bits 6:4 with every other bit 0.
- R8: A write to the status address has no effect on the flags.
- R9: While `rst_n` is low, `irq_oe` is 0. Reset clears the enables, the flags and `reg_rdata`.
- R10: A read of the control address or of an unmapped address leaves the flags unchanged. An unmapped read returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| reg_addr | input | 2 | Register select: 1 control, 2 status |
| reg_wr | input | 1 | Write strobe, one cycle |
| reg_rd | input | 1 | Read strobe, one cycle |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data, registered, held between reads |
| evt_pulse | input | 3 | Event pulses: [0] update-ended, [1] alarm, [2] periodic |
| irq_oe | output | 1 | Drive-low enable for the open-drain interrupt pin |

## Verification
The bench sends an event pulse in the same cycle as a clearing status read. A design that let the clear win would lose that event. A design that sampled the flags after the update would show the event early in the read data. Flags are also raised with their enables cleared. A design with a gated flag would then drop the event, and a design with a wrong summary bit would report an interrupt that never reached the pin. The bench writes to the status address and reads the control and unmapped addresses. A design with loose address decoding would then clear or set flags. Last, it applies reset in the middle of a run with the request active. A design whose reset did not act on the enables, the flags or the request would then fail.

// File: rtl/irq_pkg.sv
package irq_pkg;

   localparam int unsigned EVT_UPDATE   = 0;
   localparam int unsigned EVT_ALARM    = 1;
   localparam int unsigned EVT_PERIODIC = 2;

   typedef enum logic [1:0] {
      ACC_IDLE  = 2'd0,
      ACC_CTRL  = 2'd1,
      ACC_STAT  = 2'd2,
      ACC_OTHER = 2'd3
   } rd_kind_e;

endpackage

// File: rtl/irq_addr_dec.sv
module irq_addr_dec #(
   parameter int unsigned ADDR_W    = 2,
   parameter int unsigned CTRL_ADDR = 1,
   parameter int unsigned STAT_ADDR = 2
) (
   input  logic [ADDR_W-1:0] addr_i,
   input  logic              wr_i,
   input  logic              rd_i,
   output logic              ctrl_wr_o,
   output irq_pkg::rd_kind_e rd_kind_o
);
   localparam logic [ADDR_W-1:0] CtrlSel = ADDR_W'(CTRL_ADDR);
   localparam logic [ADDR_W-1:0] StatSel = ADDR_W'(STAT_ADDR);

   logic hit_ctrl;
   logic hit_stat;

   assign hit_ctrl  = (addr_i == CtrlSel);
   assign hit_stat  = (addr_i == StatSel);
   // writes to the status address fall through on purpose
   assign ctrl_wr_o = wr_i && hit_ctrl;

   always_comb begin
      if (!rd_i)          rd_kind_o = irq_pkg::ACC_IDLE;
      else if (hit_stat)  rd_kind_o = irq_pkg::ACC_STAT;
      else if (hit_ctrl)  rd_kind_o = irq_pkg::ACC_CTRL;
      else                rd_kind_o = irq_pkg::ACC_OTHER;
   end
endmodule

// File: rtl/irq_flag_cell.sv
module irq_flag_cell (
   input  logic clk,
   input  logic rst_n,
   input  logic set_i,
   input  logic clr_i,
   output logic flag_o
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      flag_o <= 1'b0;
      else if (set_i)  flag_o <= 1'b1;
      else if (clr_i)  flag_o <= 1'b0;
   end

   AST_EVENT_SETS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
      set_i |=> flag_o); // R1
   AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      (flag_o && !clr_i) |=> flag_o); // R2
endmodule

// File: rtl/irq_en_reg.sv
module irq_en_reg #(
   parameter int unsigned NUM_EVT = 3
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               wr_i,
   input  logic [NUM_EVT-1:0] wfield_i,
   output logic [NUM_EVT-1:0] en_o
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     en_o <= '0;
      else if (wr_i)  en_o <= wfield_i;
   end

   AST_ENABLE_LOADS: assert property (@(posedge clk) disable iff (!rst_n)
      wr_i |=> (en_o == $past(wfield_i))); // R7
endmodule

// File: rtl/irq_rd_path.sv
module irq_rd_path #(
   parameter int unsigned NUM_EVT     = 3,
   parameter int unsigned DATA_W      = 8,
   parameter int unsigned FLAG_LSB    = 4,
   parameter int unsigned SUMMARY_BIT = 7
) (
   input  logic               clk,
   input  logic               rst_n,
   input  irq_pkg::rd_kind_e  kind_i,
   input  logic [NUM_EVT-1:0] flags_i,
   input  logic [NUM_EVT-1:0] en_i,
   input  logic               summary_i,
   output logic [DATA_W-1:0]  rdata_o
);
   logic [DATA_W-1:0] stat_word;
   logic [DATA_W-1:0] ctrl_word;

   always_comb begin
      stat_word                           = '0;
      stat_word[FLAG_LSB +: NUM_EVT]      = flags_i;
      stat_word[SUMMARY_BIT]              = summary_i;
      ctrl_word                           = '0;
      ctrl_word[FLAG_LSB +: NUM_EVT]      = en_i;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) rdata_o <= '0;
      else begin
         unique case (kind_i)
            irq_pkg::ACC_STAT:  rdata_o <= stat_word;
            irq_pkg::ACC_CTRL:  rdata_o <= ctrl_word;
            irq_pkg::ACC_OTHER: rdata_o <= '0;
            default:            rdata_o <= rdata_o;
         endcase
      end
   end

   AST_READ_SNAPSHOT: assert property (@(posedge clk) disable iff (!rst_n)
      (kind_i == irq_pkg::ACC_STAT) |=>
         (rdata_o[FLAG_LSB +: NUM_EVT] == $past(flags_i))); // R6
   AST_SUMMARY_BIT: assert property (@(posedge clk) disable iff (!rst_n)
      (kind_i == irq_pkg::ACC_STAT) |=>
         (rdata_o[SUMMARY_BIT] == |($past(flags_i) & $past(en_i)))); // R5
endmodule

// File: rtl/irq_flag_ctrl.sv
module irq_flag_ctrl #(
   parameter int unsigned NUM_EVT     = 3,
   parameter int unsigned DATA_W      = 8,
   parameter int unsigned ADDR_W      = 2,
   parameter int unsigned FLAG_LSB    = 4,
   parameter int unsigned SUMMARY_BIT = 7,
   parameter int unsigned CTRL_ADDR   = 1,
   parameter int unsigned STAT_ADDR   = 2
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [ADDR_W-1:0]  reg_addr,
   input  logic               reg_wr,
   input  logic               reg_rd,
   input  logic [DATA_W-1:0]  reg_wdata,
   output logic [DATA_W-1:0]  reg_rdata,
   input  logic [NUM_EVT-1:0] evt_pulse,
   output logic               irq_oe
);
   localparam int unsigned FieldTop = FLAG_LSB + NUM_EVT;

   generate
      if (NUM_EVT < 1) begin : g_bad_count
         $error("NUM_EVT must be at least 1");
      end
      if (FieldTop > SUMMARY_BIT) begin : g_bad_field
         $error("flag field overlaps the summary bit");
      end
      if (SUMMARY_BIT >= DATA_W) begin : g_bad_width
         $error("summary bit outside data width");
      end
      if (CTRL_ADDR == STAT_ADDR) begin : g_bad_addr
         $error("control and status addresses must differ");
      end
   endgenerate

   logic               ctrl_wr;
   irq_pkg::rd_kind_e  rd_kind;
   logic               stat_clr;
   logic [NUM_EVT-1:0] flags;
   logic [NUM_EVT-1:0] en;
   logic               summary;
   logic               unused_wbits;

   assign unused_wbits = ^reg_wdata;

   irq_addr_dec #(
      .ADDR_W   (ADDR_W),
      .CTRL_ADDR(CTRL_ADDR),
      .STAT_ADDR(STAT_ADDR)
   ) u_dec (
      .addr_i   (reg_addr),
      .wr_i     (reg_wr),
      .rd_i     (reg_rd),
      .ctrl_wr_o(ctrl_wr),
      .rd_kind_o(rd_kind)
   );

   assign stat_clr = (rd_kind == irq_pkg::ACC_STAT);

   generate
      for (genvar i = 0; i < NUM_EVT; i++) begin : g_flag
         irq_flag_cell u_cell (
            .clk   (clk),
            .rst_n (rst_n),
            .set_i (evt_pulse[i]),
            .clr_i (stat_clr),
            .flag_o(flags[i])
         );
      end
   endgenerate

   irq_en_reg #(.NUM_EVT(NUM_EVT)) u_en (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_i    (ctrl_wr),
      .wfield_i(reg_wdata[FLAG_LSB +: NUM_EVT]),
      .en_o    (en)
   );

   assign summary = |(flags & en);
   assign irq_oe  = summary;

   irq_rd_path #(
      .NUM_EVT    (NUM_EVT),
      .DATA_W     (DATA_W),
      .FLAG_LSB   (FLAG_LSB),
      .SUMMARY_BIT(SUMMARY_BIT)
   ) u_rd (
      .clk      (clk),
      .rst_n    (rst_n),
      .kind_i   (rd_kind),
      .flags_i  (flags),
      .en_i     (en),
      .summary_i(summary),
      .rdata_o  (reg_rdata)
   );

   AST_READ_RELEASES: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_rd && reg_addr == ADDR_W'(STAT_ADDR) && evt_pulse == '0) |=> !irq_oe); // R4
   AST_RESET_RELEASES: assert property (@(posedge clk)
      !rst_n |-> !irq_oe); // R9
   AST_STATUS_WRITE_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_wr && !reg_rd && reg_addr == ADDR_W'(STAT_ADDR) && evt_pulse == '0)
         |=> $stable(flags)); // R8
   AST_OTHER_READ_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_rd && reg_addr != ADDR_W'(STAT_ADDR) && evt_pulse == '0)
         |=> $stable(flags)); // R10
endmodule

// File: tb/sim_irq_flag_ctrl.sv
module sim_irq_flag_ctrl;
   localparam logic [1:0] A_CTRL = 2'd1;
   localparam logic [1:0] A_STAT = 2'd2;
   localparam logic [1:0] A_NONE = 2'd0;

   logic       clk = 1'b0;
   logic       rst_n;
   logic [1:0] reg_addr;
   logic       reg_wr;
   logic       reg_rd;
   logic [7:0] reg_wdata;
   logic [7:0] reg_rdata;
   logic [2:0] evt_pulse;
   logic       irq_oe;

   int checks = 0;
   int fails  = 0;
   bit done   = 0;

   always #5 clk = ~clk;

   irq_flag_ctrl u0 (
      .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
      .reg_rd(reg_rd), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
      .evt_pulse(evt_pulse), .irq_oe(irq_oe)
   );

   task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   // one bus cycle: drive, wait for the edge, return just after it
   task automatic cyc(logic [1:0] a, logic w, logic r, logic [7:0] d, logic [2:0] e);
      reg_addr = a; reg_wr = w; reg_rd = r; reg_wdata = d; evt_pulse = e;
      @(posedge clk); #1;
      reg_addr = A_NONE; reg_wr = 0; reg_rd = 0; reg_wdata = 8'h00; evt_pulse = 3'b000;
   endtask

   task automatic idle(int n);
      for (int k = 0; k < n; k++) cyc(A_NONE, 0, 0, 8'h00, 3'b000);
   endtask

   task automatic do_reset();
      rst_n = 0;
      reg_addr = A_NONE; reg_wr = 0; reg_rd = 0; reg_wdata = 8'h00; evt_pulse = 3'b000;
      repeat (3) @(posedge clk);
      #1 rst_n = 1;
      idle(1);
   endtask

   task automatic t_reset_state();
      chk("R9 rdata after reset", reg_rdata, 8'h00);
      chk("R9 irq_oe after reset", {7'b0, irq_oe}, 8'h00);
      cyc(A_CTRL, 0, 1, 8'h00, 3'b000);
      chk("R9 enables cleared", reg_rdata, 8'h00);
   endtask

   task automatic t_flags_without_enable();
      cyc(A_NONE, 0, 0, 8'h00, 3'b001);
      chk("R3 no request with enables off", {7'b0, irq_oe}, 8'h00);
      cyc(A_STAT, 0, 1, 8'h00, 3'b000);
      chk("R1 R5 update flag bit4 no summary", reg_rdata, 8'h10);
      cyc(A_NONE, 0, 0, 8'h00, 3'b010);
      cyc(A_STAT, 0, 1, 8'h00, 3'b000);
      chk("R1 alarm flag bit5", reg_rdata, 8'h20);
      cyc(A_NONE, 0, 0, 8'h00, 3'b100);
      cyc(A_STAT, 0, 1, 8'h00, 3'b000);
      chk("R1 periodic flag bit6", reg_rdata, 8'h40);
   endtask

   task automatic t_sticky_and_decode();
      cyc(A_NONE, 0, 0, 8'h00, 3'b010);
      idle(5);
      cyc(A_CTRL, 0, 1, 8'h00, 3'b000);
      cyc(A_NONE, 0, 1, 8'h00, 3'b000);
      chk("R10 unmapped read is zero", reg_rdata, 8'h00);
      cyc(2'd3, 0, 1, 8'h00, 3'b000);
      cyc(A_STAT, 0, 1, 8'h00, 3'b000);
      chk("R2 R10 flag kept until status read", reg_rdata, 8'h20);
      cyc(A_STAT, 0, 1, 8'h00, 3'b000);
      chk("R4 flags cleared by read", reg_rdata, 8'h00);
   endtask

   task automatic t_enable_and_request();
      cyc(A_CTRL, 1, 0, 8'hA5, 3'b000);
      cyc(A_CTRL, 0, 1, 8'h00, 3'b000);
      chk("R7 control readback", reg_rdata, 8'h20);
      cyc(A_NONE, 0, 0, 8'h00, 3'b100);
      chk("R3 disabled source no request", {7'b0, irq_oe}, 8'h00);
      cyc(A_NONE, 0, 0, 8'h00, 3'b010);
      chk("R3 enabled source requests", {7'b0, irq_oe}, 8'h01);
      cyc(A_STAT, 0, 1, 8'h00, 3'b000);
      chk("R4 R5 status with summary", reg_rdata, 8'hE0);
      chk("R4 request released by read", {7'b0, irq_oe}, 8'h00);
   endtask

   task automatic t_status_write_ignored();
      cyc(A_NONE, 0, 0, 8'h00, 3'b001);
      cyc(A_STAT, 1, 0, 8'h00, 3'b000);
      cyc(A_STAT, 1, 0, 8'hFF, 3'b000);
      cyc(A_STAT, 0, 1, 8'h00, 3'b000);
      chk("R8 status writes ignored", reg_rdata, 8'h10);
   endtask

   task automatic t_read_collision();
      cyc(A_CTRL, 1, 0, 8'h70, 3'b000);
      cyc(A_NONE, 0, 0, 8'h00, 3'b010);
      cyc(A_STAT, 0, 1, 8'h00, 3'b100);
      chk("R6 colliding event not in read data", reg_rdata, 8'hA0);
      chk("R6 R3 request held by colliding event", {7'b0, irq_oe}, 8'h01);
      cyc(A_STAT, 0, 1, 8'h00, 3'b000);
      chk("R6 colliding event kept", reg_rdata, 8'hC0);
      chk("R4 released after second read", {7'b0, irq_oe}, 8'h00);
   endtask

   task automatic t_disable_drops_request();
      cyc(A_NONE, 0, 0, 8'h00, 3'b010);
      chk("R3 request with enable", {7'b0, irq_oe}, 8'h01);
      cyc(A_CTRL, 1, 0, 8'h00, 3'b000);
      chk("R3 request dropped on disable", {7'b0, irq_oe}, 8'h00);
      cyc(A_STAT, 0, 1, 8'h00, 3'b000);
      chk("R2 R5 flag kept, no summary", reg_rdata, 8'h20);
   endtask

   task automatic t_reset_midrun();
      cyc(A_CTRL, 1, 0, 8'h70, 3'b000);
      cyc(A_NONE, 0, 0, 8'h00, 3'b001);
      cyc(A_STAT, 0, 1, 8'h00, 3'b100);
      chk("R9 precondition request", {7'b0, irq_oe}, 8'h01);
      rst_n = 0;
      #1;
      chk("R9 request released in reset", {7'b0, irq_oe}, 8'h00);
      chk("R9 rdata cleared in reset", reg_rdata, 8'h00);
      @(posedge clk); #1 rst_n = 1;
      cyc(A_CTRL, 0, 1, 8'h00, 3'b000);
      chk("R9 enables cleared by reset", reg_rdata, 8'h00);
      cyc(A_STAT, 0, 1, 8'h00, 3'b000);
      chk("R9 flags cleared by reset", reg_rdata, 8'h00);
   endtask

   initial begin
      do_reset();
      t_reset_state();
      t_flags_without_enable();
      t_sticky_and_decode();
      t_enable_and_request();
      t_status_write_ignored();
      t_read_collision();
      t_disable_drops_request();
      t_reset_midrun();
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         checks++;
         fails++;
         $display("FAIL watchdog actual=%h expected=%h", 8'h00, 8'h01);
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   end
endmodule